// File: doc/BRIEF.md
# Single-Wire RGB LED Stream Transmitter

This block drives a daisy chain of self-clocked RGB LED drivers from one output pin. Software pushes colour bytes into a small byte queue, three per device, in the order green, red, blue. The block turns each byte into eight bit periods, most significant bit first. A bit period always opens with a rising edge. A short high portion means 0 and a long high portion means 1. One counter per bit period feeds two compare thresholds, and the current data bit chooses which of the two pulses reaches the pin.

To keep software effort low, the block asks for more data once per device's worth of bytes. It does so by raising a refill request while a stream runs and the queue has room for a whole device word. When the queue is empty at the end of a bit, the block holds the line low for a latch gap so that every device in the chain takes its new colour. Only after that gap does it report idle. Bytes written during the gap wait in the queue and start a new stream once the gap is over.

Top module: `rgb_stream_tx`

## Requirements
- R1: After a synchronous reset the line output, busy, full and refill request are all 0, and the byte queue is empty.
- R2: Bytes leave on the line in the order they were accepted, each as eight bits with the most significant bit first.
- R3: Every bit occupies exactly PERIOD clock cycles measured from rising edge to rising edge. Within one stream, bits follow one another with no idle cycles as long as the queue is not empty.
- R4: A 0 bit stays high for exactly T0H cycles and a 1 bit for exactly T1H cycles, where T0H < T1H < PERIOD.
- R5: The queue holds DEPTH bytes, and full reads 1 when it holds DEPTH bytes. A write made while full is 1 is discarded and never appears on the line.
- R6: The refill request is 1 only while bits are being sent and the queue holds at most DEPTH-3 bytes. When software answers each request with three bytes, a stream of D devices raises the request D times after the first device's bytes are written, and the stream never runs dry.
- R7: When the queue is empty at the end of a bit period, the line stays low for GAP further cycles and then busy falls. The line is low for PERIOD+GAP-1-T cycles after the last falling edge, where T is the high time of the last bit.
- R8: The line is never high while busy is 0.
- R9: A byte written during the latch gap does not shorten the gap. It is sent in a new stream that begins once busy has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one byte into the queue |
| wr_data | input | DATA_W | Byte to push |
| full | output | 1 | Queue holds DEPTH bytes |
| refill_req | output | 1 | Room for another device word while sending |
| busy | output | 1 | Stream or latch gap in progress |
| led_out | output | 1 | Serial line to the LED chain |

## Verification
The hardest state to reach from the ports is a write that lands inside the latch gap. The stimulus sends one byte, waits a fixed number of cycles computed from PERIOD and the bit count so that the line is in the gap, and then writes a second byte. The bench then expects two separate stream ends, each with a gap of exact length. The continuous-stream case also needs care. The queue is kept topped up during a sweep of all 256 byte values, and a separate run feeds three bytes only on each refill request. Both runs show that bit periods follow one another without a stall.

// File: rtl/rgbtx_pkg.sv
package rgbtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/rgbtx_fifo.sv
module rgbtx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp, wp_nxt, rp_nxt;
  logic [CW-1:0]     cnt;
  logic              push, pop;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign level = cnt;
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
    end else begin : g_cmp_wrap
      assign wp_nxt = (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp_nxt;
      if (pop)  rp <= rp_nxt;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rgbtx_bit_timer.sv
module rgbtx_bit_timer #(
  parameter int PERIOD = 60,
  parameter int T0H    = 19,
  parameter int T1H    = 38
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_val,
  output logic bit_end,
  output logic drive_hi
);
  localparam int CNTW = $clog2(PERIOD);

  logic [CNTW-1:0] cnt;
  logic            hi_zero, hi_one;

  // two compare outputs from one counter; the data bit picks one
  assign hi_zero  = (cnt < CNTW'(T0H));
  assign hi_one   = (cnt < CNTW'(T1H));
  assign drive_hi = run && (bit_val ? hi_one : hi_zero);
  assign bit_end  = run && (cnt == CNTW'(PERIOD-1));

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (bit_end)  cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rgb_stream_tx.sv
module rgb_stream_tx #(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 4,
  parameter int BYTES_PER_DEV = 3,
  parameter int PERIOD        = 60,
  parameter int T0H           = 19,
  parameter int T1H           = 38,
  parameter int GAP           = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              refill_req,
  output logic              busy,
  output logic              led_out
);
  import rgbtx_pkg::*;

  localparam int BW  = $clog2(DATA_W);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int GW  = $clog2(GAP);

  tx_state_t         st;
  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bits_left;
  logic [GW-1:0]     gcnt;
  logic              led_q;

  logic [DATA_W-1:0] rd_data;
  logic              empty, pop;
  logic [CW-1:0]     fifo_level;
  logic              bit_end, drive_hi;

  rgbtx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop), .rd_data(rd_data), .empty(empty), .full(full),
    .level(fifo_level)
  );

  rgbtx_bit_timer #(.PERIOD(PERIOD), .T0H(T0H), .T1H(T1H)) u_timer (
    .clk(clk), .rst(rst), .run(st == ST_SEND), .bit_val(sh[DATA_W-1]),
    .bit_end(bit_end), .drive_hi(drive_hi)
  );

  always_comb begin
    pop = 1'b0;
    case (st)
      ST_IDLE: pop = !empty;
      ST_SEND: pop = bit_end && (bits_left == '0) && !empty;
      default: pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sh        <= '0;
      bits_left <= '0;
      gcnt      <= '0;
      led_q     <= 1'b0;
    end else begin
      led_q <= drive_hi;
      case (st)
        ST_IDLE: begin
          if (!empty) begin
            sh        <= rd_data;
            bits_left <= BW'(DATA_W-1);
            st        <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (bit_end) begin
            if (bits_left != '0) begin
              sh        <= sh << 1;
              bits_left <= bits_left - 1'b1;
            end else if (!empty) begin
              sh        <= rd_data;
              bits_left <= BW'(DATA_W-1);
            end else begin
              gcnt <= '0;
              st   <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP-1)) st   <= ST_IDLE;
          else                    gcnt <= gcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign led_out    = led_q;
  assign busy       = (st != ST_IDLE);
  assign refill_req = (st == ST_SEND) &&
                      (fifo_level <= CW'(DEPTH-BYTES_PER_DEV));
endmodule

// File: rtl/rgb_stream_tx_chk.sv
module rgb_stream_tx_chk #(
  parameter int DEPTH  = 4,
  parameter int PERIOD = 60,
  parameter int T0H    = 19,
  parameter int T1H    = 38
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic full,
  input logic refill_req,
  input logic busy,
  input logic led_out,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
  logic [15:0] hi_cnt, per_cnt;
  logic        led_d, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= '0;
      per_cnt <= '0;
      led_d   <= 1'b0;
      seen    <= 1'b0;
    end else begin
      led_d  <= led_out;
      hi_cnt <= led_out ? hi_cnt + 1'b1 : 16'd0;
      if (led_out && !led_d)      per_cnt <= 16'd1;
      else if (per_cnt != 16'hFFFF) per_cnt <= per_cnt + 1'b1;
      if (!busy)                  seen <= 1'b0;
      else if (led_out && !led_d) seen <= 1'b1;
    end
  end

  p_bit_period_r3: assert property (@(posedge clk) disable iff (rst)
    (led_out && !led_d && seen) |-> (per_cnt == 16'(PERIOD)));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    (led_d && !led_out) |-> (hi_cnt == 16'(T0H) || hi_cnt == 16'(T1H)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> (fifo_level <= $past(fifo_level)));

  p_refill_active_r6: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (busy && !full));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !led_out);
endmodule

bind rgb_stream_tx rgb_stream_tx_chk #(
  .DEPTH(DEPTH), .PERIOD(PERIOD), .T0H(T0H), .T1H(T1H)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .full(full),
  .refill_req(refill_req), .busy(busy), .led_out(led_out),
  .fifo_level(fifo_level)
);

// File: tb/rgb_stream_tx_test.sv
module rgb_stream_tx_test;
  localparam int P   = 12;
  localparam int T0  = 4;
  localparam int T1  = 8;
  localparam int GP  = 40;
  localparam int DEP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       full, refill_req, busy, led_out;

  always #2.5 clk = ~clk;

  rgb_stream_tx #(.DATA_W(8), .DEPTH(DEP), .BYTES_PER_DEV(3), .PERIOD(P),
                  .T0H(T0), .T1H(T1), .GAP(GP)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .refill_req(refill_req), .busy(busy), .led_out(led_out)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_mem [0:1023];
  logic [7:0] rx_mem  [0:1023];
  int exp_n = 0, rx_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // line monitor: decodes pulses independently of the design
  logic led_prev = 0, busy_prev = 0, rf_prev = 0, last_bit = 0, sess = 0;
  int hi = 0, since_rise = 0, low_cnt = 0, nbits = 0;
  int rf_rises = 0, busy_falls = 0;
  logic [7:0] rx_byte = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (led_out && !busy) chk(0, "R8 line high while idle", 1, 0);
      if (led_out && !led_prev) begin
        if (sess) chk(since_rise == P, "R3 bit period", since_rise, P);
        sess = 1; since_rise = 1; hi = 1;
      end else begin
        since_rise++;
        if (led_out) hi++;
      end
      if (!led_out && led_prev) begin
        chk(hi == T0 || hi == T1, "R4 high width", hi, T0);
        last_bit = (hi == T1);
        rx_byte = {rx_byte[6:0], last_bit};
        nbits++;
        if (nbits == 8) begin rx_mem[rx_n] = rx_byte; rx_n++; nbits = 0; end
        low_cnt = 1;
      end else if (!led_out && busy) low_cnt++;
      if (!busy && busy_prev) begin
        chk(low_cnt == P + GP - 1 - (last_bit ? T1 : T0), "R7 latch gap",
            low_cnt, P + GP - 1 - (last_bit ? T1 : T0));
        busy_falls++; sess = 0;
      end
      if (refill_req && !rf_prev) rf_rises++;
      led_prev = led_out; busy_prev = busy; rf_prev = refill_req;
    end
  end

  bit saw_full = 0;
  task automatic push(input logic [7:0] b, input bit wait_room);
    @(negedge clk);
    if (wait_room) while (full) @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    if (full) saw_full = 1;
    else begin exp_mem[exp_n] = b; exp_n++; end
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int f0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(led_out == 0, "R1 led_out", led_out, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(full == 0, "R1 full", full, 0);
    chk(refill_req == 0, "R1 refill_req", refill_req, 0);

    // R2/R3 exhaustive byte sweep with the queue kept topped up
    f0 = busy_falls;
    for (int v = 0; v < 256; v++) push(8'(v), 1);
    wait_idle();
    chk(busy_falls - f0 == 1, "R3 continuous sweep stream", busy_falls - f0, 1);

    // R5 overflow: six back-to-back writes from idle
    saw_full = 0;
    f0 = exp_n;
    for (int k = 0; k < 6; k++) push(8'(8'hA0 + k), 0);
    chk(saw_full == 1, "R5 full seen", saw_full, 1);
    chk(exp_n - f0 == 5, "R5 accepted count", exp_n - f0, 5);
    wait_idle();

    // R6 refill-driven stream of four devices
    f0 = busy_falls;
    for (int k = 0; k < 3; k++) push(8'(8'h30 + k), 1);
    r0 = rf_rises;
    for (int d = 1; d < 4; d++) begin
      logic pr;
      pr = refill_req;
      forever begin
        @(negedge clk);
        if (refill_req && !pr) break;
        pr = refill_req;
      end
      for (int k = 0; k < 3; k++) push(8'(8'h30 + 3*d + k), 1);
    end
    wait_idle();
    chk(rf_rises - r0 == 4, "R6 one request per device", rf_rises - r0, 4);
    chk(busy_falls - f0 == 1, "R6 no underrun", busy_falls - f0, 1);

    // R9 write during latch gap
    f0 = busy_falls;
    push(8'h5A, 1);
    repeat (8*P + 10) @(negedge clk);
    chk(busy == 1 && led_out == 0, "R9 in gap before write", busy, 1);
    push(8'hC3, 1);
    while (busy_falls - f0 < 2) @(negedge clk);
    wait_idle();
    chk(busy_falls - f0 == 2, "R9 two streams", busy_falls - f0, 2);

    // R2 order and MSB-first content
    chk(rx_n == exp_n, "R2 byte count", rx_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(rx_mem[i] == exp_mem[i], "R2 byte value", rx_mem[i], exp_mem[i]);

    done = 1;
    summary();
    $finish;
  end
endmodule